// File: doc/BRIEF.md
# Upper Memory Bank Switch Controller

This block decides where each CPU access to the top 12 KB of a 16-bit address space goes. Reads there come either from ROM or from RAM. Writes are enabled or blocked separately from the read source. The lowest 4 KB window of that region, `$D000-$DFFF`, can be backed by one of two RAM banks. The other bank is relocated to a spare physical window, so both banks fit in one flat RAM array. The memory arrays are not part of the block. It only produces steering information: a ROM/RAM read select, a write enable, the physical RAM offset, and whether the main or auxiliary RAM copy is used.

The configuration lives in a three-bit state register. Any access, read or write, to the sixteen switch locations `$C080-$C08F` loads that register from the low address bits. The steering outputs are combinational in the current state, the current address and the auxiliary-copy select input. A change of the auxiliary select therefore applies to the very next access, with no reprogramming needed. Two status bits let software see the bank choice and whether region reads currently come from RAM.

Top module: `lc_bank_ctrl`

## Requirements
- R1: A valid access (read or write) whose address lies in `$C080-$C08F` loads the state register on that clock edge. Address bit 3 becomes the bank bit, and address bits 1:0 become the mode. Address bit 2 has no effect. The new state is visible from the next cycle.
- R2: In mode 00, region reads come from RAM (`rd_from_rom`=0) and region writes are blocked (`wr_en`=0).
- R3: In mode 01, region reads come from ROM (`rd_from_rom`=1) and valid region writes are enabled (`wr_en`=1).
- R4: In mode 10, region reads come from ROM and region writes are blocked.
- R5: In mode 11, region reads come from RAM and valid region writes are enabled.
- R6: With the bank bit at 0, `ram_offset` equals the CPU address. With the bank bit at 1, an address in `$D000-$DFFF` maps to `ram_offset` = address − `$1000` (physical `$C000-$CFFF`). Addresses `$E000-$FFFF` keep `ram_offset` = address whatever the bank bit is.
- R7: For a region access, `use_aux` equals the `alt_sel` input in the same cycle, with no clock delay.
- R8: `stat_bank2` is 1 exactly when the bank bit is 0. `stat_rd_ram` is 1 exactly when the two mode bits are equal.
- R9: After reset the state is bank bit 0 and mode 00. Both status bits read 1, and region writes are blocked.
- R10: A valid access outside `$C080-$C08F` leaves the state unchanged. An address below `$D000` gives `in_region`=0, `rd_from_rom`=0, `wr_en`=0 and `use_aux`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | A CPU access is present this cycle |
| cpu_we | input | 1 | The access is a write |
| cpu_addr | input | 16 | CPU address |
| alt_sel | input | 1 | Select the auxiliary RAM copy for the region |
| in_region | output | 1 | The address lies in `$D000-$FFFF` |
| rd_from_rom | output | 1 | Region reads are served by ROM |
| wr_en | output | 1 | Write strobe to region RAM (valid write, writes enabled) |
| ram_offset | output | 16 | Physical RAM offset for the access |
| use_aux | output | 1 | Region access uses the auxiliary RAM copy |
| stat_bank2 | output | 1 | Status: bank bit is 0 |
| stat_rd_ram | output | 1 | Status: region reads come from RAM |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the switch block at `$C080`, the region starting at `$D000` and the relocated bank at `$C000`. With these values, all sixteen switch addresses can be swept, which covers every combination of bank bit, mode bits and the ignored bit 2. Each state is crossed with both auxiliary settings, with reads and writes, and with probe addresses at both edges of the banked window, in the fixed upper window, and below the region. The expected read source, write enable, offset and status are derived arithmetically from the switch address.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

    typedef enum logic [1:0] {
        LC_RAM_RO  = 2'b00,
        LC_ROM_WR  = 2'b01,
        LC_ROM_RO  = 2'b10,
        LC_RAM_RW  = 2'b11
    } lc_mode_e;

    typedef struct packed {
        logic     bank1;
        lc_mode_e mode;
    } lc_state_t;

    typedef struct packed {
        logic hit;
        logic rd_rom;
        logic wr_en;
        logic aux;
    } lc_steer_t;

    localparam lc_state_t LC_RESET_STATE = '{bank1: 1'b0, mode: LC_RAM_RO};

    // Bits 3, 1 and 0 of the switch address form the state; bit 2 is dropped.
    function automatic lc_state_t lc_capture(input logic [3:0] low);
        lc_state_t s;
        s.bank1 = low[3];
        s.mode  = lc_mode_e'(low[1:0]);
        return s;
    endfunction

    function automatic logic lc_reads_rom(input lc_mode_e m);
        return m[1] ^ m[0];
    endfunction

    function automatic logic lc_writes_ok(input lc_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/lcb_switch_reg.sv
module lcb_switch_reg
    import lcb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SW_SPAN_W = 4,
    parameter logic [ADDR_W-1:0] SW_BASE = 16'hC080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    output lc_state_t         state
);
    localparam int TAG_W = ADDR_W - SW_SPAN_W;
    localparam logic [TAG_W-1:0] SW_TAG = SW_BASE[ADDR_W-1:SW_SPAN_W];

    logic sw_hit;
    assign sw_hit = cpu_valid && (cpu_addr[ADDR_W-1:SW_SPAN_W] == SW_TAG);

    always_ff @(posedge clk) begin
        if (rst)
            state <= LC_RESET_STATE;
        else if (sw_hit)
            state <= lc_capture(cpu_addr[3:0]);
    end
endmodule

// File: rtl/lcb_mapper.sv
module lcb_mapper
    import lcb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] REGION_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] BANKED_SIZE = 16'h1000,
    parameter logic [ADDR_W-1:0] BANK1_PHYS  = 16'hC000
) (
    input  lc_state_t         state,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              alt_sel,
    output lc_steer_t         steer,
    output logic [ADDR_W-1:0] ram_offset
);
    localparam logic [ADDR_W-1:0] BANKED_END = REGION_BASE + BANKED_SIZE;
    localparam logic [ADDR_W-1:0] RELOC      = REGION_BASE - BANK1_PHYS;

    logic in_banked;

    always_comb begin
        steer.hit    = (cpu_addr >= REGION_BASE);
        in_banked    = steer.hit && (cpu_addr < BANKED_END);
        steer.rd_rom = steer.hit && lc_reads_rom(state.mode);
        steer.wr_en  = steer.hit && cpu_valid && cpu_we && lc_writes_ok(state.mode);
        steer.aux    = steer.hit && alt_sel;
        ram_offset   = (in_banked && state.bank1) ? (cpu_addr - RELOC) : cpu_addr;
    end
endmodule

// File: rtl/lcb_status.sv
module lcb_status
    import lcb_pkg::*;
(
    input  lc_state_t state,
    output logic      stat_bank2,
    output logic      stat_rd_ram
);
    always_comb begin
        stat_bank2  = ~state.bank1;
        stat_rd_ram = ~lc_reads_rom(state.mode);
    end
endmodule

// File: rtl/lc_bank_ctrl.sv
module lc_bank_ctrl
    import lcb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SW_SPAN_W = 4,
    parameter logic [ADDR_W-1:0] SW_BASE     = 16'hC080,
    parameter logic [ADDR_W-1:0] REGION_BASE = 16'hD000,
    parameter logic [ADDR_W-1:0] BANKED_SIZE = 16'h1000,
    parameter logic [ADDR_W-1:0] BANK1_PHYS  = 16'hC000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              alt_sel,
    output logic              in_region,
    output logic              rd_from_rom,
    output logic              wr_en,
    output logic [ADDR_W-1:0] ram_offset,
    output logic              use_aux,
    output logic              stat_bank2,
    output logic              stat_rd_ram
);
    lc_state_t state;
    lc_steer_t steer;

    lcb_switch_reg #(
        .ADDR_W(ADDR_W), .SW_SPAN_W(SW_SPAN_W), .SW_BASE(SW_BASE)
    ) u_sw (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid),
        .cpu_addr(cpu_addr), .state(state)
    );

    lcb_mapper #(
        .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE),
        .BANKED_SIZE(BANKED_SIZE), .BANK1_PHYS(BANK1_PHYS)
    ) u_map (
        .state(state), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .alt_sel(alt_sel),
        .steer(steer), .ram_offset(ram_offset)
    );

    lcb_status u_stat (
        .state(state), .stat_bank2(stat_bank2), .stat_rd_ram(stat_rd_ram)
    );

    assign in_region   = steer.hit;
    assign rd_from_rom = steer.rd_rom;
    assign wr_en       = steer.wr_en;
    assign use_aux     = steer.aux;
endmodule

// File: rtl/lc_bank_ctrl_chk.sv
module lc_bank_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              alt_sel,
    input logic              in_region,
    input logic              rd_from_rom,
    input logic              wr_en,
    input logic [ADDR_W-1:0] ram_offset,
    input logic              use_aux,
    input logic              stat_bank2,
    input logic              stat_rd_ram
);
    logic sw_acc;
    logic d_win;
    logic upper_win;
    assign sw_acc    = cpu_valid && (cpu_addr[15:4] == 12'hC08);
    assign d_win     = (cpu_addr[15:12] == 4'hD);
    assign upper_win = (cpu_addr[15:13] == 3'b111);

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        sw_acc |=> (stat_bank2 == !$past(cpu_addr[3])) &&
                   (stat_rd_ram == ($past(cpu_addr[1]) == $past(cpu_addr[0])))); // R1

    AST_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !sw_acc |=> $stable(stat_bank2) && $stable(stat_rd_ram)); // R10

    AST_ROM_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
        in_region |-> (rd_from_rom == !stat_rd_ram)); // R8

    AST_WR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (in_region && cpu_valid && cpu_we)); // R2

    AST_UPPER_OFFSET: assert property (@(posedge clk) disable iff (rst)
        upper_win |-> (ram_offset == cpu_addr)); // R6

    AST_BANK2_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (d_win && stat_bank2) |-> (ram_offset == cpu_addr)); // R6

    AST_BANK1_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (d_win && !stat_bank2) |-> (ram_offset == cpu_addr - 16'h1000)); // R6

    AST_AUX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_region |-> (use_aux == alt_sel)); // R7

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_region |-> !rd_from_rom && !wr_en && !use_aux); // R10

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> stat_bank2 && stat_rd_ram); // R9
endmodule

bind lc_bank_ctrl lc_bank_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .alt_sel(alt_sel), .in_region(in_region),
    .rd_from_rom(rd_from_rom), .wr_en(wr_en), .ram_offset(ram_offset),
    .use_aux(use_aux), .stat_bank2(stat_bank2), .stat_rd_ram(stat_rd_ram)
);

// File: tb/tb_lc_bank_ctrl.sv
module tb_lc_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        alt_sel = 1'b0;
    logic        in_region, rd_from_rom, wr_en, use_aux, stat_bank2, stat_rd_ram;
    logic [15:0] ram_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lc_bank_ctrl dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .alt_sel(alt_sel), .in_region(in_region),
        .rd_from_rom(rd_from_rom), .wr_en(wr_en), .ram_offset(ram_offset),
        .use_aux(use_aux), .stat_bank2(stat_bank2), .stat_rd_ram(stat_rd_ram)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at addr %h: actual %h expected %h", req, cpu_addr, act, exp);
        end
    endtask

    task automatic do_switch(input logic [3:0] low, input logic we);
        @(negedge clk);
        cpu_addr  = 16'hC080 | {12'h0, low};
        cpu_valid = 1'b1;
        cpu_we    = we;
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_we    = 1'b0;
    endtask

    // Expected values derived from the switch nibble that last loaded state
    task automatic probe(input logic [3:0] sw, input logic [15:0] a, input logic we,
                         input logic alt);
        logic [1:0]  m;
        logic        reg_hit, exp_rom, exp_wen;
        logic [15:0] exp_off;
        @(negedge clk);
        cpu_addr  = a;
        cpu_valid = 1'b1;
        cpu_we    = we;
        alt_sel   = alt;
        #2;
        m       = {sw[1], sw[0]};
        reg_hit = (a >= 16'hD000);
        exp_rom = reg_hit && (m == 2'b01 || m == 2'b10);
        exp_wen = reg_hit && we && (m == 2'b01 || m == 2'b11);
        exp_off = (sw[3] && a[15:12] == 4'hD) ? a - 16'h1000 : a;
        check("R10 in_region", {15'h0, in_region}, {15'h0, reg_hit});
        case (m)
            2'b00: check("R2 rd_from_rom", {15'h0, rd_from_rom}, {15'h0, exp_rom});
            2'b01: check("R3 rd_from_rom", {15'h0, rd_from_rom}, {15'h0, exp_rom});
            2'b10: check("R4 rd_from_rom", {15'h0, rd_from_rom}, {15'h0, exp_rom});
            default: check("R5 rd_from_rom", {15'h0, rd_from_rom}, {15'h0, exp_rom});
        endcase
        case (m)
            2'b00: check("R2 wr_en", {15'h0, wr_en}, {15'h0, exp_wen});
            2'b01: check("R3 wr_en", {15'h0, wr_en}, {15'h0, exp_wen});
            2'b10: check("R4 wr_en", {15'h0, wr_en}, {15'h0, exp_wen});
            default: check("R5 wr_en", {15'h0, wr_en}, {15'h0, exp_wen});
        endcase
        check("R6 ram_offset", ram_offset, exp_off);
        check("R7 use_aux", {15'h0, use_aux}, {15'h0, reg_hit && alt});
    endtask

    initial begin
        logic [15:0] probes [6];
        probes[0] = 16'hD000; probes[1] = 16'hD5A3; probes[2] = 16'hDFFF;
        probes[3] = 16'hE000; probes[4] = 16'hFFFF; probes[5] = 16'hC000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state, bank bit 0 and mode 00
        check("R9 stat_bank2", {15'h0, stat_bank2}, 16'h1);
        check("R9 stat_rd_ram", {15'h0, stat_rd_ram}, 16'h1);
        probe(4'h0, 16'hD123, 1'b1, 1'b0);

        for (int s = 0; s < 16; s++) begin
            logic [3:0] sw;
            sw = 4'(s);
            do_switch(sw, s[0] ^ s[2]);
            // R1 load, R8 status encoding
            check("R1 R8 stat_bank2", {15'h0, stat_bank2}, {15'h0, !sw[3]});
            check("R1 R8 stat_rd_ram", {15'h0, stat_rd_ram}, {15'h0, sw[1] == sw[0]});
            for (int p = 0; p < 6; p++)
                for (int k = 0; k < 4; k++)
                    probe(sw, probes[p], k[0], k[1]);
            // R10: region and low accesses have not disturbed the state
            @(negedge clk);
            cpu_valid = 1'b0;
            check("R10 stat_bank2 held", {15'h0, stat_bank2}, {15'h0, !sw[3]});
            check("R10 stat_rd_ram held", {15'h0, stat_rd_ram}, {15'h0, sw[1] == sw[0]});
        end

        // R7: alt_sel flips between back-to-back accesses take effect immediately
        do_switch(4'hB, 1'b0);
        probe(4'hB, 16'hD800, 1'b1, 1'b1);
        probe(4'hB, 16'hD800, 1'b1, 1'b0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule